// File: doc/BRIEF.md
# Load Element Width Converter

This block sits after the data read port of a load unit. It takes the raw word returned by memory and turns it into one destination element. The bytes that belong to the access size are first put into the right order for the current endianness and the instruction's byte-reverse variant. The value is then fitted to the destination element width, either by plain zero-extension and truncation or by clamping to the destination range, signed or unsigned.

It is a two-stage pipeline. Stage one selects the bytes and reorders them. Stage two extends, truncates or clamps the value. A valid bit travels with the data. The result is in the low bits of a 64-bit output, and a flag reports that clamping changed the value. It accepts one element per cycle with no stalls.

Top module: `ld_elem_convert`

## Requirements
- R1: `out_valid` equals the `in_valid` of exactly two clock cycles earlier, so a new element can be accepted every cycle. After reset `out_valid`, `out_data` and `out_sat` are all zero.
- R2: The bytes are reversed when `in_brev` equals `in_le` (the XNOR of the two bits). When the two bits differ, the bytes keep their memory order.
- R3: Only the low bytes covered by the access size take part. Reversal swaps byte b with byte (n-1-b) of those n bytes. Bytes of `in_data` above the access size are discarded.
- R4: With `in_sat`=0, the ordered value is zero-extended to the destination width, or its low bits are kept when the destination is narrower.
- R5: With `in_sat`=1 and `in_signed`=0, the value is treated as unsigned. A value above 2^dw-1 becomes dw ones.
- R6: With `in_sat`=1 and `in_signed`=1, the value is sign-extended from the access size. It is then clamped to the range -2^(dw-1) to 2^(dw-1)-1 and written in dw-bit two's complement.
- R7: Bits of `out_data` at and above the destination width are zero.
- R8: `out_sat` is 1 only when clamping changed the value. It is always 0 when `in_sat`=0.
- R9: The size codes on `in_opw` and `in_dstw` are 0=8 bits, 1=16 bits, 2=32 bits and 3=64 bits.
- R10: For a 64-bit destination, saturation never clamps. Unsigned mode passes the value unchanged, and signed mode passes the sign-extended value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element valid |
| in_data | input | 64 | Raw memory read word, with the access in its low bytes |
| in_opw | input | 2 | Access size code |
| in_brev | input | 1 | Byte-reverse variant of the instruction |
| in_le | input | 1 | Little-endian mode |
| in_dstw | input | 2 | Destination element width code |
| in_sat | input | 1 | Saturation enable |
| in_signed | input | 1 | 1 selects signed saturation, 0 selects unsigned |
| out_valid | output | 1 | Output element valid |
| out_data | output | 64 | Converted element, zero above the destination width |
| out_sat | output | 1 | Clamping changed the value |

## Verification
A wrong byte-order decision or a wrong size selection in the first stage shows up as permuted or missing bytes in `out_data`. This is visible two cycles after the input is taken. A wrong control bit carried between the stages gives the result or the flag of another mode for that same element only. The bench sweeps every pairing of size, destination width, order bits and saturation mode over boundary data patterns, so any such fault is seen on the element that carries it.

// File: rtl/ldconv_pkg.sv
package ldconv_pkg;

   localparam int WORD_W = 64;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } size_e;

   typedef struct packed {
      size_e opw;
      size_e dstw;
      logic  sat;
      logic  sgn;
   } conv_ctl_t;

endpackage

// File: rtl/ldconv_swap.sv
module ldconv_swap
   import ldconv_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_brev,
   input  logic              in_le,
   input  conv_ctl_t         in_ctl,
   output logic              s1_valid,
   output logic [DATA_W-1:0] s1_data,
   output conv_ctl_t         s1_ctl
);
   localparam int NBYTES = DATA_W / 8;
   localparam int NSIZES = $clog2(NBYTES) + 1;

   logic [DATA_W-1:0] rev_c [NSIZES];
   logic [DATA_W-1:0] str_c [NSIZES];
   logic              do_swap;
   logic [DATA_W-1:0] sel_data;

   for (genvar k = 0; k < NSIZES; k++) begin : g_size
      localparam int NB = 1 << k;
      logic [DATA_W-1:0] rv;
      logic [DATA_W-1:0] sv;
      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign rv[8*b +: 8] = in_data[8*(NB-1-b) +: 8];
         assign sv[8*b +: 8] = in_data[8*b +: 8];
      end
      if (NB < NBYTES) begin : g_pad
         assign rv[DATA_W-1:8*NB] = '0;
         assign sv[DATA_W-1:8*NB] = '0;
      end
      assign rev_c[k] = rv;
      assign str_c[k] = sv;
   end

   assign do_swap  = ~(in_brev ^ in_le);
   assign sel_data = do_swap ? rev_c[in_ctl.opw] : str_c[in_ctl.opw];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_data  <= '0;
         s1_ctl   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_data <= sel_data;
            s1_ctl  <= in_ctl;
         end
      end
   end

   // R1: valid follows the input one stage later
   assert_stage1_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);
   assert_stage1_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !s1_valid);
   // R3: a byte access never carries bytes above its size
   assert_byte_access_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ctl.opw == SZ_B) |=> (s1_data[DATA_W-1:8] == '0));

endmodule

// File: rtl/ldconv_fit.sv
module ldconv_fit
   import ldconv_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_valid,
   input  logic [DATA_W-1:0] s1_data,
   input  conv_ctl_t         s1_ctl,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sat
);
   localparam int NBYTES = DATA_W / 8;
   localparam int NSIZES = $clog2(NBYTES) + 1;

   logic [DATA_W-1:0] sx_c  [NSIZES];
   logic [DATA_W-1:0] res_c [NSIZES];
   logic              flg_c [NSIZES];
   logic [DATA_W-1:0] sx;

   // sign extension from the access size
   for (genvar k = 0; k < NSIZES; k++) begin : g_sext
      localparam int OB = 8 << k;
      if (OB < DATA_W) begin : g_ext
         assign sx_c[k] = {{(DATA_W-OB){s1_data[OB-1]}}, s1_data[OB-1:0]};
      end else begin : g_full
         assign sx_c[k] = s1_data;
      end
   end
   assign sx = sx_c[s1_ctl.opw];

   // one fitting variant per destination width
   for (genvar k = 0; k < NSIZES; k++) begin : g_dst
      localparam int DB = 8 << k;
      if (DB < DATA_W) begin : g_narrow
         logic            u_over;
         logic            s_fits;
         logic [DB-1:0]   s_lim;
         assign u_over = |s1_data[DATA_W-1:DB];
         assign s_fits = (&sx[DATA_W-1:DB-1]) | ~(|sx[DATA_W-1:DB-1]);
         assign s_lim  = sx[DATA_W-1] ? {1'b1, {(DB-1){1'b0}}}
                                      : {1'b0, {(DB-1){1'b1}}};
         always_comb begin
            flg_c[k] = 1'b0;
            res_c[k] = '0;
            if (!s1_ctl.sat) begin
               res_c[k][DB-1:0] = s1_data[DB-1:0];
            end else if (!s1_ctl.sgn) begin
               flg_c[k]         = u_over;
               res_c[k][DB-1:0] = u_over ? {DB{1'b1}} : s1_data[DB-1:0];
            end else begin
               flg_c[k]         = ~s_fits;
               res_c[k][DB-1:0] = s_fits ? sx[DB-1:0] : s_lim;
            end
         end
      end else begin : g_wide
         assign flg_c[k] = 1'b0;
         assign res_c[k] = (s1_ctl.sat && s1_ctl.sgn) ? sx : s1_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sat   <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_data <= res_c[s1_ctl.dstw];
            out_sat  <= flg_c[s1_ctl.dstw];
         end
      end
   end

   // R1: second stage forwards valid
   assert_stage2_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);
   // R8: no flag without saturation enabled
   assert_flag_needs_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_ctl.sat) |=> !out_sat);
   // R7: byte destination leaves upper bits clear
   assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_ctl.dstw == SZ_B) |=> (out_data[DATA_W-1:8] == '0));
   // R5: unsigned overflow into a byte gives all ones and a flag
   assert_unsigned_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_ctl.sat && !s1_ctl.sgn && s1_ctl.dstw == SZ_B
       && (s1_data[DATA_W-1:8] != '0))
      |=> (out_data == DATA_W'(8'hFF) && out_sat));

endmodule

// File: rtl/ld_elem_convert.sv
module ld_elem_convert
   import ldconv_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        in_opw,
   input  logic              in_brev,
   input  logic              in_le,
   input  logic [1:0]        in_dstw,
   input  logic              in_sat,
   input  logic              in_signed,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sat
);
   if (DATA_W != WORD_W) begin : g_bad_width
      $error("ld_elem_convert: DATA_W must equal the 64-bit word the size codes address");
   end

   conv_ctl_t         in_ctl;
   conv_ctl_t         s1_ctl;
   logic              s1_valid;
   logic [DATA_W-1:0] s1_data;

   assign in_ctl.opw  = size_e'(in_opw);
   assign in_ctl.dstw = size_e'(in_dstw);
   assign in_ctl.sat  = in_sat;
   assign in_ctl.sgn  = in_signed;

   ldconv_swap #(.DATA_W(DATA_W)) u_swap (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_brev  (in_brev),
      .in_le    (in_le),
      .in_ctl   (in_ctl),
      .s1_valid (s1_valid),
      .s1_data  (s1_data),
      .s1_ctl   (s1_ctl)
   );

   ldconv_fit #(.DATA_W(DATA_W)) u_fit (
      .clk       (clk),
      .rst_n     (rst_n),
      .s1_valid  (s1_valid),
      .s1_data   (s1_data),
      .s1_ctl    (s1_ctl),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_sat   (out_sat)
   );

endmodule

// File: tb/sim_ld_elem_convert.sv
module sim_ld_elem_convert;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic [1:0]  in_opw = '0;
   logic        in_brev = 1'b0;
   logic        in_le = 1'b0;
   logic [1:0]  in_dstw = '0;
   logic        in_sat = 1'b0;
   logic        in_signed = 1'b0;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_sat;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ld_elem_convert u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_opw(in_opw), .in_brev(in_brev), .in_le(in_le), .in_dstw(in_dstw),
      .in_sat(in_sat), .in_signed(in_signed),
      .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat)
   );

   // arithmetic reference built from the requirements
   function automatic void model(input logic [63:0] d, input int ow, input bit br,
                                 input bit le, input int dw, input bit sat, input bit sg,
                                 output logic [63:0] r, output bit f);
      int          nb = 1 << ow;
      int          obits = 8 << ow;
      int          dbits = 8 << dw;
      bit          sw = (br == le);
      logic [63:0] v = '0;
      logic [63:0] mask;
      longint      s;
      longint      hi;
      longint      lo;
      for (int b = 0; b < nb; b++)
         v[8*b +: 8] = sw ? d[8*(nb-1-b) +: 8] : d[8*b +: 8];
      mask = (dbits == 64) ? '1 : ((64'd1 << dbits) - 64'd1);
      f = 1'b0;
      if (!sat) begin
         r = v & mask;
      end else if (!sg) begin
         if (v > mask) begin r = mask; f = 1'b1; end
         else r = v;
      end else begin
         s = $signed(v);
         if (obits < 64 && v[obits-1]) s = $signed(v | ~((64'd1 << obits) - 64'd1));
         if (dbits == 64) begin
            r = 64'(s);
         end else begin
            hi = (longint'(1) <<< (dbits-1)) - 1;
            lo = -hi - 1;
            if (s > hi) begin r = 64'(hi); f = 1'b1; end
            else if (s < lo) begin r = 64'(lo) & mask; f = 1'b1; end
            else r = 64'(s) & mask;
         end
      end
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp,
                        input bit gf, input bit ef);
      compared++;
      if (got !== exp || gf !== ef) begin
         mismatched++;
         $display("FAIL %s: data=%h sat=%0b, expected data=%h sat=%0b", req, got, gf, exp, ef);
      end
   endtask

   task automatic check_bit(input string req, input logic got, input logic exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %0b, expected %0b", req, got, exp);
      end
   endtask

   // single element: drive, then look two edges later and one edge after that
   task automatic one(input string req, input logic [63:0] d, input int ow, input bit br,
                      input bit le, input int dw, input bit sat, input bit sg,
                      input logic [63:0] exp, input bit ef);
      in_valid = 1'b1; in_data = d; in_opw = 2'(ow); in_brev = br; in_le = le;
      in_dstw = 2'(dw); in_sat = sat; in_signed = sg;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check_bit("R1 valid after two cycles", out_valid, 1'b1);
      check(req, out_data, exp, out_sat, ef);
      @(negedge clk);
      check_bit("R1 valid drops with input", out_valid, 1'b0);
   endtask

   logic [63:0] pats [8];
   logic [63:0] ring_r [4];
   bit          ring_f [4];

   initial begin
      pats[0] = 64'h0000_0000_0000_0000;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h0123_4567_89AB_CDEF;
      pats[3] = 64'h0000_0000_0000_0080;
      pats[4] = 64'h0000_0000_0000_007F;
      pats[5] = 64'h0000_0000_0000_80FF;
      pats[6] = 64'h8000_0000_0000_0000;
      pats[7] = 64'hFEDC_BA98_7654_3210;

      repeat (3) @(negedge clk);
      // R1: reset state
      check_bit("R1 reset out_valid", out_valid, 1'b0);
      check("R1 reset outputs", out_data, 64'h0, out_sat, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: order decision from brev XNOR le
      one("R2 no swap brev0 le1", 64'h1122, 1, 0, 1, 3, 0, 0, 64'h1122, 0);
      one("R2 swap brev0 le0",    64'h1122, 1, 0, 0, 3, 0, 0, 64'h2211, 0);
      one("R2 swap brev1 le1",    64'h1122, 1, 1, 1, 3, 0, 0, 64'h2211, 0);
      one("R2 no swap brev1 le0", 64'h1122, 1, 1, 0, 3, 0, 0, 64'h1122, 0);
      // R3: reversal confined to the access size
      one("R3 word swap drops upper", 64'hAABB_CCDD_1122_3344, 2, 0, 0, 3, 0, 0,
          64'h4433_2211, 0);
      // R9: code 3 is the full 64-bit word
      one("R9 full word swap", 64'h0102_0304_0506_0708, 3, 1, 1, 3, 0, 0,
          64'h0807_0605_0403_0201, 0);
      // R4: zero-extension
      one("R4 zero extend byte", 64'h80, 0, 0, 1, 2, 0, 0, 64'h80, 0);
      // R7: truncation clears upper bits
      one("R7 truncate to byte", 64'hDEAD_BEEF_0000_1234, 3, 0, 1, 0, 0, 0, 64'h34, 0);
      // R8: no flag when not saturating
      one("R8 no flag without sat", 64'hFFFF_FFFF_FFFF_FFFF, 3, 0, 1, 0, 0, 0, 64'hFF, 0);
      // R5: unsigned clamp and edge
      one("R5 unsigned over", 64'h0100, 1, 0, 1, 0, 1, 0, 64'hFF, 1);
      one("R5 unsigned at max", 64'h00FF, 1, 0, 1, 0, 1, 0, 64'hFF, 0);
      // R6: signed clamp both sides and in-range
      one("R6 signed in range", 64'hFF80, 1, 0, 1, 0, 1, 1, 64'h80, 0);
      one("R6 signed high clamp", 64'h0080, 1, 0, 1, 0, 1, 1, 64'h7F, 1);
      one("R6 signed low clamp", 64'h8000, 1, 0, 1, 0, 1, 1, 64'h80, 1);
      one("R6 signed widen", 64'h80, 0, 0, 1, 1, 1, 1, 64'hFF80, 0);
      // R10: 64-bit destination never clamps
      one("R10 signed to 64", 64'h80, 0, 0, 1, 3, 1, 1, 64'hFFFF_FFFF_FFFF_FF80, 0);
      one("R10 unsigned to 64", 64'hFFFF_FFFF_FFFF_FFFF, 3, 0, 1, 3, 1, 0,
          64'hFFFF_FFFF_FFFF_FFFF, 0);

      // back-to-back sweep over every control pairing (R1..R10)
      begin
         int n = 0;
         string tag;
         for (int ow = 0; ow < 4; ow++)
         for (int dw = 0; dw < 4; dw++)
         for (int br = 0; br < 2; br++)
         for (int le = 0; le < 2; le++)
         for (int sat = 0; sat < 2; sat++)
         for (int sg = 0; sg < 2; sg++)
         for (int p = 0; p < 8; p++) begin
            if (n >= 2) begin
               check_bit("R1 streaming valid", out_valid, 1'b1);
               check("R4/R5/R6 sweep", out_data, ring_r[(n-2)%4], out_sat, ring_f[(n-2)%4]);
            end
            in_valid = 1'b1; in_data = pats[p]; in_opw = 2'(ow); in_brev = br[0];
            in_le = le[0]; in_dstw = 2'(dw); in_sat = sat[0]; in_signed = sg[0];
            model(pats[p], ow, br[0], le[0], dw, sat[0], sg[0], ring_r[n%4], ring_f[n%4]);
            n++;
            @(negedge clk);
         end
         in_valid = 1'b0;
         for (int t = 0; t < 2; t++) begin
            tag = "R4/R5/R6 sweep tail";
            check_bit("R1 streaming valid", out_valid, 1'b1);
            check(tag, out_data, ring_r[(n-2+t)%4], out_sat, ring_f[(n-2+t)%4]);
            @(negedge clk);
         end
         check_bit("R1 idle after stream", out_valid, 1'b0);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL R1: watchdog expired, got hung run, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule